// File: doc/BRIEF.md
# Burst Column Order Generator

This block turns the start of a memory burst into the column offsets the DRAM visits, one offset per beat on the beat clock. A start strobe captures a starting column, a burst length of four or eight beats and a burst type (sequential or interleaved). The block then presents the beats on a valid/ready output stream with a last-beat flag.

The low three column bits are reordered as the mode requires. All column bits above bit 2 are copied unchanged from the start column onto every beat. In sequential mode a burst of eight stays inside the start nibble for four beats, wrapping modulo four. It then moves to the other nibble and starts there at the same low two bits. In interleaved mode each beat's offset is the start offset XORed with the beat number.

The output is back-pressured by the consumer. A beat stays on the port, unchanged, until it is accepted with valid and ready both high. Only then does the next beat appear. There is no input buffering. A start strobe that arrives while a burst is still on the port is dropped, and a one-cycle error pulse reports it.

Top module: `burst_col_order`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `beat_valid_o` and `busy_err_o` are low.
- R2: Sequential, burst of four (`bl8_i`=0, `intlv_i`=0): beat i carries low offset {s[2], (s[1:0]+i) mod 4}, where s is the start column's low three bits (start 2 gives 2,3,0,1).
- R3: Sequential, burst of eight (`bl8_i`=1, `intlv_i`=0): beats 0-3 carry {s[2], (s[1:0]+i) mod 4}, and beats 4-7 carry {~s[2], (s[1:0]+i) mod 4`} (start 5 gives 5,6,7,4,1,2,3,0; start 3 gives 3,0,1,2,7,4,5,6).
- R4: Interleaved (`intlv_i`=1): beat i carries low offset s XOR i for i in 0..3 or 0..7.
- R5: On every beat, column bits above bit 2 equal those of the start column. With a burst of four, bit 2 also equals the start column's bit 2.
- R6: While `beat_valid_o` is high and `beat_ready_i` is low, the column and last flag on the port hold their values. A beat advances only on a handshake.
- R7: `beat_last_o` is high only together with `beat_valid_o`, and only on the fourth beat (burst of four) or the eighth beat (burst of eight).
- R8: A start seen while `beat_valid_o` is low makes beat 0 valid on the next cycle. When the last beat is accepted, `beat_valid_o` is low on the next cycle.
- R9: A start seen while `beat_valid_o` is high is ignored. It does not change the burst, and `busy_err_o` is high on exactly the next cycle for that strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe, sampled on the rising edge |
| start_col_i | input | COL_W | Starting column |
| bl8_i | input | 1 | Burst length: 0 = four beats, 1 = eight beats |
| intlv_i | input | 1 | Burst type: 0 = sequential, 1 = interleaved |
| beat_ready_i | input | 1 | Consumer accepts the current beat |
| beat_valid_o | output | 1 | A beat is presented |
| beat_col_o | output | COL_W | Column address of the current beat |
| beat_last_o | output | 1 | Current beat is the final one of the burst |
| busy_err_o | output | 1 | One-cycle pulse: a start was dropped because a burst was in progress |

## Verification
The embedded assertions check, on every cycle, the stream rules. They cover holding a stalled beat, the last flag never appearing without valid, valid falling after the last accepted beat, an idle start producing beat 0, upper column bits staying constant inside a burst, and every error pulse having a dropped start behind it. The column ordering itself (nibble wrap for eight-beat sequential bursts, XOR order, bit 2 kept for four-beat bursts) and the beat on which the last flag rises can only be shown by the bench. Its model predicts each beat of every start offset and mode, under random back-pressure and with starts that collide with running bursts.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int LOW_W   = 3;
  localparam int BEAT_W  = 3;
  localparam int NIB_W   = 2;
  localparam logic [BEAT_W-1:0] LAST_BL4 = 3'd3;
  localparam logic [BEAT_W-1:0] LAST_BL8 = 3'd7;

  typedef struct packed {
    logic             bl8;
    logic             intlv;
    logic [LOW_W-1:0] start_lo;
  } burst_cfg_t;
endpackage

// File: rtl/burst_offset_map.sv
module burst_offset_map
  import burst_col_pkg::*;
(
  input  burst_cfg_t        cfg_i,
  input  logic [BEAT_W-1:0] idx_i,
  output logic [LOW_W-1:0]  off_o,
  output logic              last_o
);
  logic [NIB_W-1:0] nib_pos;
  logic             nib_sel;

  always_comb begin
    nib_pos = cfg_i.start_lo[NIB_W-1:0] + idx_i[NIB_W-1:0];
    if (cfg_i.bl8)
      nib_sel = cfg_i.start_lo[LOW_W-1] ^ idx_i[BEAT_W-1];
    else
      nib_sel = cfg_i.start_lo[LOW_W-1];
    if (cfg_i.intlv)
      off_o = cfg_i.start_lo ^ idx_i;
    else
      off_o = {nib_sel, nib_pos};
    last_o = cfg_i.bl8 ? (idx_i == LAST_BL8) : (idx_i == LAST_BL4);
  end
endmodule

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic              bl8_i,
  input  logic              intlv_i,
  input  logic              ready_i,
  input  logic              last_i,
  output logic              valid_o,
  output logic [BEAT_W-1:0] idx_o,
  output burst_cfg_t        cfg_o,
  output logic [COL_W-1:0]  col_o,
  output logic              err_o
);
  logic fire;
  assign fire = valid_o && ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_o <= 1'b0;
      idx_o   <= '0;
      cfg_o   <= '0;
      col_o   <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= start_i && valid_o;
      if (!valid_o) begin
        if (start_i) begin
          valid_o        <= 1'b1;
          idx_o          <= '0;
          col_o          <= start_col_i;
          cfg_o.bl8      <= bl8_i;
          cfg_o.intlv    <= intlv_i;
          cfg_o.start_lo <= start_col_i[LOW_W-1:0];
        end
      end else if (fire) begin
        if (last_i) valid_o <= 1'b0;
        else        idx_o   <= idx_o + 1'b1;
      end
    end
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && !ready_i |=> valid_o && $stable(idx_o) && $stable(cfg_o) && $stable(col_o));
  // R8
  idle_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o && start_i |=> valid_o && (idx_o == '0));
  // R8
  end_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o && ready_i && last_i |=> !valid_o);
  // R9
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i && valid_o));
endmodule

// File: rtl/burst_col_order.sv
module burst_col_order
  import burst_col_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             bl8_i,
  input  logic             intlv_i,
  input  logic             beat_ready_i,
  output logic             beat_valid_o,
  output logic [COL_W-1:0] beat_col_o,
  output logic             beat_last_o,
  output logic             busy_err_o
);
  logic [BEAT_W-1:0] idx;
  burst_cfg_t        cfg;
  logic [COL_W-1:0]  col_q;
  logic [LOW_W-1:0]  off;
  logic              last_raw;

  burst_seq_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .bl8_i(bl8_i), .intlv_i(intlv_i), .ready_i(beat_ready_i), .last_i(last_raw),
    .valid_o(beat_valid_o), .idx_o(idx), .cfg_o(cfg), .col_o(col_q), .err_o(busy_err_o)
  );

  burst_offset_map u_map (
    .cfg_i(cfg), .idx_i(idx), .off_o(off), .last_o(last_raw)
  );

  generate
    if (COL_W > LOW_W) begin : g_upper
      assign beat_col_o = {col_q[COL_W-1:LOW_W], off};
      // R5
      upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid_o && !(beat_ready_i && beat_last_o) |=>
        $stable(beat_col_o[COL_W-1:LOW_W]));
    end else begin : g_flat
      assign beat_col_o = off[COL_W-1:0];
    end
  endgenerate

  assign beat_last_o = beat_valid_o && last_raw;

  // R7
  last_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);
endmodule

// File: tb/sim_burst_col_order.sv
`timescale 1ns/1ps
module sim_burst_col_order;
  localparam int CW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, bl8_i = 1'b0, intlv_i = 1'b0, beat_ready_i = 1'b0;
  logic [CW-1:0] start_col_i = '0;
  logic beat_valid_o, beat_last_o, busy_err_o;
  logic [CW-1:0] beat_col_o;

  burst_col_order #(.COL_W(CW)) u0 (.*);

  always #2.5 clk = ~clk;

  int vecs = 0, bad = 0;
  int q_col[$];
  string q_tag[$];
  int q_up[$];
  bit exp_err = 0, stalled = 0;
  int prev_col = 0, prev_last = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(beat_valid_o == (q_col.size() > 0), "R8", beat_valid_o, q_col.size() > 0);
    chk(busy_err_o == exp_err, "R9", busy_err_o, exp_err);
    if (q_col.size() > 0 && beat_valid_o) begin
      chk(beat_col_o == q_col[0], q_tag[0], beat_col_o, q_col[0]);
      chk(int'(beat_col_o[CW-1:3]) == q_up[0], "R5", beat_col_o[CW-1:3], q_up[0]);
      chk(beat_last_o == (q_col.size() == 1), "R7", beat_last_o, q_col.size() == 1);
      if (stalled) begin
        chk(beat_col_o == prev_col, "R6", beat_col_o, prev_col);
        chk(beat_last_o == prev_last, "R6", beat_last_o, prev_last);
      end
    end else begin
      chk(beat_last_o == 1'b0, "R7", beat_last_o, 0);
    end
    prev_col = beat_col_o;
    prev_last = beat_last_o;
  endtask

  task automatic push_burst(input int c, input bit b8, input bit il);
    int s = c & 7;
    int up = c >> 3;
    int n = b8 ? 8 : 4;
    for (int i = 0; i < n; i++) begin
      int off;
      string tag;
      if (il) begin off = s ^ i; tag = "R4"; end
      else if (!b8) begin off = (s & 4) | ((s + i) & 3); tag = "R2"; end
      else begin
        off = ((i < 4) ? (s & 4) : ((s & 4) ^ 4)) | ((s + i) & 3);
        tag = "R3";
      end
      q_col.push_back((up << 3) | off);
      q_tag.push_back(tag);
      q_up.push_back(up);
    end
  endtask

  task automatic step(input bit st, input int c, input bit b8, input bit il, input bit rdy);
    bit busy = q_col.size() > 0;
    start_i = st; start_col_i = c[CW-1:0]; bl8_i = b8; intlv_i = il; beat_ready_i = rdy;
    exp_err = st && busy;
    stalled = busy && !rdy;
    if (busy && rdy) begin
      void'(q_col.pop_front()); void'(q_tag.pop_front()); void'(q_up.pop_front());
    end
    if (st && !busy) push_burst(c, b8, il);
    @(posedge clk);
    @(negedge clk);
    compare();
  endtask

  task automatic drain(input bit rnd);
    int guard = 0;
    while (q_col.size() > 0 && guard < 200) begin
      step(0, 0, 0, 0, rnd ? 1'($urandom % 2) : 1'b1);
      guard++;
    end
    step(0, 0, 0, 0, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs low during reset
    chk(beat_valid_o == 0, "R1", beat_valid_o, 0);
    chk(busy_err_o == 0, "R1", busy_err_o, 0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(beat_valid_o == 0, "R1", beat_valid_o, 0);
    chk(busy_err_o == 0, "R1", busy_err_o, 0);

    // every start offset in every mode, no back-pressure (R2 R3 R4 R5)
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++) begin
        step(1, (((s * 37 + m * 11) & 127) << 3) | s, m[0], m[1], 1);
        drain(0);
      end

    // random back-pressure with colliding starts (R6 R9)
    for (int k = 0; k < 60; k++) begin
      step(1, int'($urandom % 1024), 1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2));
      for (int j = 0; j < 10; j++)
        step(($urandom % 4) == 0, int'($urandom % 1024), 1'($urandom % 2),
             1'($urandom % 2), 1'($urandom % 2));
      drain(1);
    end

    // start coinciding with last-beat handshake is dropped (R8 R9)
    step(1, 10'h2A5, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 1);
    step(1, 10'h113, 1, 0, 1);
    step(0, 0, 0, 0, 1);

    // held start strobe across a stalled burst (R9 R6)
    step(1, 10'h3F4, 1, 1, 0);
    for (int j = 0; j < 5; j++) step(1, 10'h001, 0, 0, 0);
    drain(0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule